// File: doc/BRIEF.md
# Serial NOR Flash Command Controller

This block is the device side of a serial NOR flash that is reached over a four-wire SPI link in mode 0. An active-low select and a serial clock frame each command. Both are oversampled by the system clock through two-stage synchronizers. The block decodes an opcode byte, a 24-bit address and any data bytes. It keeps a status byte that holds a busy flag, a write-enable latch, the block-protect code, a top/bottom selector and a status-write lock. It also owns a small on-chip byte array.

Reads and status reads are served while the frame is in progress. Program, erase, status-write, write-enable, write-disable, power-down and release commands take effect when the select line rises. They take effect only if every clock pulse of the frame belongs to a whole byte. A program loads a page buffer while the frame runs and commits it to the array after the select line rises. Erases walk their aligned region and write FFh to every byte. In both cases the busy period lasts a parameter number of system clocks, or the length of the walk if that is longer.

The controller has three states. `ST_IDLE` is standby. `ST_BUSY` is an internal cycle. `ST_DPD` is deep power-down. The transitions are:
- `ST_IDLE -> ST_BUSY` when a modifying command is accepted at select rise.
- `ST_BUSY -> ST_IDLE` when the busy counter reaches its last cycle.
- `ST_IDLE -> ST_DPD` on an accepted power-down command.
- `ST_DPD -> ST_IDLE` on an accepted release command.

Top module: `sflash_ctrl`

## Requirements
- R1: Status write (01h), page program (02h), sector erase (20h), block erase (D8h) and chip erase (C7h) are ignored unless the write-enable latch is 1 when select rises. An ignored command causes no busy period and no array change.
- R2: Write enable (06h) sets the write-enable latch and write disable (04h) clears it. Reset clears it, and so does the end of every status-write, program or erase cycle.
- R3: Read status (05h) returns the status byte on every byte after the opcode, refreshed at each byte boundary. The bit layout is: bit 7 the status-write lock, bit 6 always 0, bit 5 the top/bottom selector, bits 4:2 the protect code, bit 1 the write-enable latch, bit 0 the busy flag.
- R4: Read (03h) followed by a 24-bit address, MSB first, returns the byte at that address and then the bytes at following addresses. The address wraps from the last array byte to address 0.
- R5: Page program (02h), with an address and 1 to 256 data bytes, ANDs each data byte into the stored byte. The data address wraps inside the 256-byte page. The command needs at least 5 bytes.
- R6: Sector erase (20h, 1 KB region), block erase (D8h, 2 KB region) and chip erase (C7h, whole array) set every byte of the aligned region that contains the address to FFh. Sector and block erase need at least 4 bytes.
- R7: A command that acts at select rise is discarded, with no state change, if the number of clock pulses in its frame is not a multiple of eight.
- R8: An accepted modifying command starts a busy period. Its length is max(T, walk length) system clocks, where T is T_WRSR, T_PP, T_SE, T_BE or T_CE and the walk length is 0, 256, 1024, 2048 or the array size. The busy flag reads 1 throughout the period. During it, every command except read status is ignored.
- R9: Protect code 0 protects nothing. Codes 1, 2 and 3 protect 1/8, 1/4 and 1/2 of the array, and codes 4 to 7 protect all of it. The protected range grows from the top end when the selector is 0 and from address 0 when it is 1. A program or erase whose region touches a protected byte is refused, and a chip erase is refused whenever the code is not 0. A refused command leaves the write-enable latch unchanged.
- R10: Status write, with at least 2 bytes, copies data bits 7, 5 and 4:2 into the lock, the selector and the protect code. It is ignored when the lock is 1 and the write-protect input is low.
- R11: Power-down (B9h) enters deep power-down. There, every command is ignored except release (ABh), which returns to standby. Release answers with the fixed signature byte on every byte after three dummy bytes.
- R12: Input bits are captured on rising serial-clock edges and output bits change on falling edges, MSB first. The output is 0 while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the device |
| wp_n | input | 1 | Active-low hardware write-protect |
| miso | output | 1 | Serial data out of the device |

## Verification
Each serial edge reaches the controller three system clocks after the pin changes: two synchronizer stages and one edge-detect register. An output bit therefore appears on `miso` three clocks after the falling serial edge. The bench holds each clock phase for four system clocks and samples `miso` just before the next rising edge. Select-rise actions, including the start of a busy period, are in place three clocks after select rises, and the bench waits ten clocks before it starts the next frame. Busy lengths are checked at both ends: a status read that finishes a few hundred clocks before max(T, walk) runs out must still show busy, and polling must later see busy clear together with the write-enable latch.

// File: rtl/sflash_pkg.sv
`timescale 1ns/1ps
package sflash_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DPD} dev_state_t;
    typedef enum logic [2:0] {JOB_NONE, JOB_WRSR, JOB_PROG, JOB_SECT, JOB_BLK, JOB_CHIP} job_t;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WRSR = 8'h01;
    localparam logic [7:0] OPC_READ = 8'h03;
    localparam logic [7:0] OPC_PROG = 8'h02;
    localparam logic [7:0] OPC_SECT = 8'h20;
    localparam logic [7:0] OPC_BLK  = 8'hD8;
    localparam logic [7:0] OPC_CHIP = 8'hC7;
    localparam logic [7:0] OPC_DPD  = 8'hB9;
    localparam logic [7:0] OPC_REL  = 8'hAB;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/sflash_spi_if.sv
`timescale 1ns/1ps
module sflash_spi_if (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       frame_start,
    output logic       frame_end,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic [2:0] bit_phase,
    output logic       miso
);
    logic [1:0] cs_s;
    logic [2:0] sck_s;
    logic [1:0] mosi_s;
    logic       cs_prev;
    logic [6:0] sh;
    logic [7:0] txr;
    logic       active, rise, fall;

    assign active      = ~cs_s[1];
    assign rise        = active & sck_s[1] & ~sck_s[2];
    assign fall        = active & ~sck_s[1] & sck_s[2];
    assign frame_start = ~cs_s[1] & cs_prev;
    assign frame_end   = cs_s[1] & ~cs_prev;
    assign byte_done   = rise && (bit_phase == 3'd7);
    assign rx_byte     = {sh, mosi_s[1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_s      <= 2'b11;
            sck_s     <= 3'b000;
            mosi_s    <= 2'b00;
            cs_prev   <= 1'b1;
            sh        <= '0;
            bit_phase <= '0;
            txr       <= '0;
            miso      <= 1'b0;
        end else begin
            cs_s    <= {cs_s[0], cs_n};
            sck_s   <= {sck_s[1:0], sck};
            mosi_s  <= {mosi_s[0], mosi};
            cs_prev <= cs_s[1];
            if (!active) begin
                bit_phase <= '0;
                txr       <= '0;
                miso      <= 1'b0;
            end else begin
                if (rise) begin
                    sh        <= {sh[5:0], mosi_s[1]};
                    bit_phase <= bit_phase + 3'd1;
                end
                if (tx_load) begin
                    txr <= tx_byte;
                end else if (fall) begin
                    miso <= txr[7];
                    txr  <= {txr[6:0], 1'b0};
                end
            end
        end
    end

    // R12
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s[1] && cs_prev) |=> (miso == 1'b0));
endmodule

// File: rtl/sflash_prot.sv
`timescale 1ns/1ps
module sflash_prot #(
    parameter int unsigned MEM_BYTES = 4096,
    parameter int unsigned AW        = 12
) (
    input  logic [2:0]    bp,
    input  logic          tb,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic [AW:0] sz;
    logic [AW:0] a_ext;

    assign a_ext = {1'b0, addr};

    always_comb begin
        case (bp)
            3'd0:    sz = '0;
            3'd1:    sz = (AW+1)'(MEM_BYTES / 8);
            3'd2:    sz = (AW+1)'(MEM_BYTES / 4);
            3'd3:    sz = (AW+1)'(MEM_BYTES / 2);
            default: sz = (AW+1)'(MEM_BYTES);
        endcase
        if (sz == '0)
            hit = 1'b0;
        else if (tb)
            hit = a_ext < sz;
        else
            hit = a_ext >= ((AW+1)'(MEM_BYTES) - sz);
    end
endmodule

// File: rtl/sflash_array.sv
`timescale 1ns/1ps
module sflash_array #(
    parameter int unsigned MEM_BYTES  = 4096,
    parameter int unsigned PAGE_BYTES = 256,
    parameter int unsigned AW         = 12,
    parameter int unsigned PW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_clr,
    input  logic          buf_we,
    input  logic [PW-1:0] buf_idx,
    input  logic [7:0]    buf_din,
    input  logic          we,
    input  logic          prog,
    input  logic [AW-1:0] waddr,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0]            mem  [MEM_BYTES];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pval;
    logic [PW-1:0]         widx;
    logic [7:0]            pbyte;

    assign widx  = waddr[PW-1:0];
    assign pbyte = pval[widx] ? pbuf[widx] : 8'hFF;
    assign rdata = mem[raddr];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= prog ? (mem[waddr] & pbyte) : 8'hFF;
        if (buf_we)
            pbuf[buf_idx] <= buf_din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pval <= '0;
        else if (buf_clr)
            pval <= '0;
        else if (buf_we)
            pval[buf_idx] <= 1'b1;
    end
endmodule

// File: rtl/sflash_ctrl.sv
`timescale 1ns/1ps
module sflash_ctrl
    import sflash_pkg::*;
#(
    parameter int unsigned MEM_BYTES    = 4096,
    parameter int unsigned PAGE_BYTES   = 256,
    parameter int unsigned SECTOR_BYTES = 1024,
    parameter int unsigned BLOCK_BYTES  = 2048,
    parameter int unsigned T_WRSR       = 32,
    parameter int unsigned T_PP         = 300,
    parameter int unsigned T_SE         = 1100,
    parameter int unsigned T_BE         = 2100,
    parameter int unsigned T_CE         = 4200,
    parameter logic [7:0]  SIG_BYTE     = 8'h15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic wp_n,
    output logic miso
);
    localparam int unsigned AW     = $clog2(MEM_BYTES);
    localparam int unsigned PW     = $clog2(PAGE_BYTES);
    localparam int unsigned D_WRSR = umax(T_WRSR, 1);
    localparam int unsigned D_PP   = umax(T_PP, PAGE_BYTES);
    localparam int unsigned D_SE   = umax(T_SE, SECTOR_BYTES);
    localparam int unsigned D_BE   = umax(T_BE, BLOCK_BYTES);
    localparam int unsigned D_CE   = umax(T_CE, MEM_BYTES);
    localparam int unsigned D_MAX  = umax(umax(umax(D_PP, D_SE), umax(D_BE, D_CE)), D_WRSR);
    localparam int unsigned CW     = $clog2(D_MAX + 1);

    dev_state_t st, st_n;
    job_t       job, new_job;
    logic [CW-1:0] cnt, span, dur;
    logic [AW-1:0] base, cmd_addr, req_mask, req_lo, req_hi, waddr, rd_addr, rd_ptr;
    logic [PW-1:0] pp_ptr;
    logic [23:0]   addr, new_addr;
    logic [7:0]    opc, sr_new, status, rx_byte, tx_byte, rdata, cur;
    logic [3:0]    nbytes;
    logic [2:0]    sr_bp, bit_phase;
    logic          wel, sr_srwd, sr_tb;
    logic          frame_start, frame_end, byte_done;
    logic          lo_hit, hi_hit, w_hit, blocked;
    logic          commit, go_wrsr, go_job, busy_last, arr_we, buf_clr, buf_we;

    sflash_spi_if u_spi (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .tx_load(byte_done), .tx_byte(tx_byte),
        .frame_start(frame_start), .frame_end(frame_end), .byte_done(byte_done),
        .rx_byte(rx_byte), .bit_phase(bit_phase), .miso(miso)
    );

    sflash_prot #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_prot_lo (
        .bp(sr_bp), .tb(sr_tb), .addr(req_lo), .hit(lo_hit));
    sflash_prot #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_prot_hi (
        .bp(sr_bp), .tb(sr_tb), .addr(req_hi), .hit(hi_hit));
    sflash_prot #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_prot_wr (
        .bp(sr_bp), .tb(sr_tb), .addr(waddr), .hit(w_hit));

    sflash_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .AW(AW), .PW(PW)) u_array (
        .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(pp_ptr),
        .buf_din(rx_byte), .we(arr_we), .prog(job == JOB_PROG), .waddr(waddr),
        .raddr(rd_addr), .rdata(rdata)
    );

    assign status   = {sr_srwd, 1'b0, sr_tb, sr_bp, wel, st == ST_BUSY};
    assign cmd_addr = addr[AW-1:0];
    assign new_addr = {addr[15:0], rx_byte};
    assign req_lo   = cmd_addr & ~req_mask;
    assign req_hi   = req_lo | req_mask;
    assign blocked  = lo_hit || hi_hit;
    assign commit   = frame_end && (bit_phase == 3'd0) && (nbytes != 4'd0);
    assign go_wrsr  = (opc == OPC_WRSR) && (nbytes >= 4'd2) && wel && !(sr_srwd && !wp_n);
    assign busy_last = (st == ST_BUSY) && (cnt == dur - CW'(1));
    assign arr_we   = (st == ST_BUSY) && (job != JOB_WRSR) && (job != JOB_NONE) && (cnt < span);
    assign waddr    = base + cnt[AW-1:0];
    assign buf_clr  = byte_done && (nbytes == 4'd0) && (rx_byte == OPC_PROG) && (st == ST_IDLE);
    assign buf_we   = byte_done && (opc == OPC_PROG) && (nbytes >= 4'd4) && (st == ST_IDLE);
    assign rd_addr  = (nbytes == 4'd3) ? new_addr[AW-1:0] : rd_ptr;
    assign cur      = (nbytes == 4'd0) ? rx_byte : opc;

    // decode of the command held at select rise
    always_comb begin
        req_mask = '0;
        new_job  = JOB_NONE;
        unique case (opc)
            OPC_PROG: begin
                req_mask = AW'(PAGE_BYTES - 1);
                if (nbytes >= 4'd5 && wel && !blocked) new_job = JOB_PROG;
            end
            OPC_SECT: begin
                req_mask = AW'(SECTOR_BYTES - 1);
                if (nbytes >= 4'd4 && wel && !blocked) new_job = JOB_SECT;
            end
            OPC_BLK: begin
                req_mask = AW'(BLOCK_BYTES - 1);
                if (nbytes >= 4'd4 && wel && !blocked) new_job = JOB_BLK;
            end
            OPC_CHIP: begin
                req_mask = '1;
                if (wel && sr_bp == 3'd0) new_job = JOB_CHIP;
            end
            OPC_WRSR: if (go_wrsr) new_job = JOB_WRSR;
            default: ;
        endcase
    end
    assign go_job = (new_job != JOB_NONE);

    always_comb begin
        unique case (job)
            JOB_WRSR: begin span = '0;                dur = CW'(D_WRSR); end
            JOB_PROG: begin span = CW'(PAGE_BYTES);   dur = CW'(D_PP);   end
            JOB_SECT: begin span = CW'(SECTOR_BYTES); dur = CW'(D_SE);   end
            JOB_BLK:  begin span = CW'(BLOCK_BYTES);  dur = CW'(D_BE);   end
            JOB_CHIP: begin span = CW'(MEM_BYTES);    dur = CW'(D_CE);   end
            default:  begin span = '0;                dur = CW'(1);      end
        endcase
    end

    always_comb begin
        tx_byte = 8'h00;
        if (cur == OPC_RDSR && st != ST_DPD) tx_byte = status;
        if (cur == OPC_REL && st != ST_BUSY && nbytes >= 4'd3) tx_byte = SIG_BYTE;
        if (cur == OPC_READ && st == ST_IDLE && nbytes >= 4'd3) tx_byte = rdata;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: if (commit && go_job) st_n = ST_BUSY;
                     else if (commit && opc == OPC_DPD) st_n = ST_DPD;
            ST_BUSY: if (busy_last) st_n = ST_IDLE;
            ST_DPD:  if (commit && opc == OPC_REL) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            job <= JOB_NONE; cnt <= '0; base <= '0; wel <= 1'b0;
            sr_srwd <= 1'b0; sr_tb <= 1'b0; sr_bp <= '0;
            opc <= '0; nbytes <= '0; addr <= '0; sr_new <= '0;
            pp_ptr <= '0; rd_ptr <= '0;
        end else begin
            if (frame_start) begin
                nbytes <= '0;
                opc    <= '0;
            end
            if (byte_done) begin
                if (nbytes != 4'hF) nbytes <= nbytes + 4'd1;
                if (nbytes == 4'd0) opc <= rx_byte;
                if (nbytes >= 4'd1 && nbytes <= 4'd3) addr <= new_addr;
                if (nbytes == 4'd1) sr_new <= rx_byte;
                if (nbytes == 4'd3) pp_ptr <= new_addr[PW-1:0];
                if (buf_we) pp_ptr <= pp_ptr + PW'(1);
                if (nbytes >= 4'd3) rd_ptr <= rd_addr + AW'(1);
            end
            if (commit && st == ST_IDLE) begin
                if (opc == OPC_WREN) wel <= 1'b1;
                if (opc == OPC_WRDI) wel <= 1'b0;
                if (go_wrsr) begin
                    sr_srwd <= sr_new[7];
                    sr_tb   <= sr_new[5];
                    sr_bp   <= sr_new[4:2];
                end
                if (go_job) begin
                    job  <= new_job;
                    cnt  <= '0;
                    base <= req_lo;
                end
            end
            if (st == ST_BUSY) begin
                cnt <= cnt + CW'(1);
                if (busy_last) begin
                    wel <= 1'b0;
                    job <= JOB_NONE;
                end
            end
        end
    end

    // R1
    wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_BUSY) |-> $past(wel));
    // R2
    wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_last |=> (!wel && st == ST_IDLE));
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && !busy_last) |=> (st == ST_BUSY && $stable(sr_bp)));
    // R9
    prot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !w_hit);
    // R10
    hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_srwd && !wp_n) |=> $stable({sr_srwd, sr_tb, sr_bp}));
    // R11
    dpd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DPD) |=> ($stable(wel) && $stable(sr_bp) && !arr_we));
endmodule

// File: tb/sflash_ctrl_bench.sv
`timescale 1ns/1ps
module sflash_ctrl_bench;
    localparam int unsigned MEMB = 4096;
    localparam int unsigned TWR  = 32;
    localparam int unsigned TPP  = 300;
    localparam int unsigned TSE  = 1100;
    localparam int unsigned TBE  = 2100;
    localparam int unsigned TCE  = 4200;
    localparam logic [7:0]  SIG  = 8'h15;
    localparam int unsigned DBE  = (TBE > 2048) ? TBE : 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic wp_n = 1'b1;
    logic miso;
    int   checks = 0;
    int   errs = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    sflash_ctrl #(.MEM_BYTES(MEMB), .PAGE_BYTES(256), .SECTOR_BYTES(1024), .BLOCK_BYTES(2048),
                  .T_WRSR(TWR), .T_PP(TPP), .T_SE(TSE), .T_BE(TBE), .T_CE(TCE), .SIG_BYTE(SIG))
        u_sflash_ctrl (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
                       .wp_n(wp_n), .miso(miso));

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fbegin();
        @(negedge clk);
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic fend();
        tick(4);
        cs_n = 1'b1;
        tick(10);
    endtask

    task automatic xfer(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = t[i];
            tick(4);
            r[i] = miso;
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
        end
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            mosi = v[7-i];
            tick(4);
            sck = 1'b1;
            tick(4);
            sck = 1'b0;
        end
    endtask

    task automatic put_addr(input logic [23:0] a);
        logic [7:0] d;
        xfer(a[23:16], d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        fbegin(); xfer(op, d); fend();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        fbegin(); xfer(8'h05, d); xfer(8'h00, s); fend();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        fbegin(); xfer(8'h01, d); xfer(v, d); fend();
    endtask

    task automatic addr_cmd(input logic [7:0] op, input logic [23:0] a);
        logic [7:0] d;
        fbegin(); xfer(op, d); put_addr(a); fend();
    endtask

    task automatic read2(input logic [23:0] a, output logic [7:0] b0, output logic [7:0] b1);
        logic [7:0] d;
        fbegin(); xfer(8'h03, d); put_addr(a); xfer(8'h00, b0); xfer(8'h00, b1); fend();
    endtask

    task automatic prog(input logic [23:0] a, input int n,
                        input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic [7:0] d;
        fbegin(); xfer(8'h02, d); put_addr(a);
        xfer(d0, d);
        if (n > 1) xfer(d1, d);
        if (n > 2) xfer(d2, d);
        fend();
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 400; k++) begin
            rdsr(s);
            if (!s[0]) break;
        end
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk({7'd0, miso}, 8'h00, "R12 miso low while deselected");
        rdsr(s); chk(s, 8'h00, "R3 status after reset");
    endtask

    task automatic t_latch();
        logic [7:0] s;
        cmd1(8'h06); rdsr(s); chk(s, 8'h02, "R2 write enable sets latch");
        cmd1(8'h04); rdsr(s); chk(s, 8'h00, "R2 write disable clears latch");
    endtask

    task automatic t_chip_erase();
        logic [7:0] s, a, b;
        cmd1(8'h06); cmd1(8'hC7);
        rdsr(s); chk(s, 8'h03, "R8 busy and latch during chip erase");
        wait_idle();
        rdsr(s); chk(s, 8'h00, "R2 latch cleared after chip erase");
        read2(24'h000000, a, b); chk(a, 8'hFF, "R6 chip erase byte 0");
        read2(24'h000ABC, a, b); chk(b, 8'hFF, "R6 chip erase byte ABD");
    endtask

    task automatic t_no_wel();
        logic [7:0] s, a, b;
        prog(24'h000100, 1, 8'h00, 8'h00, 8'h00);
        rdsr(s); chk(s, 8'h00, "R1 program without latch not busy");
        read2(24'h000100, a, b); chk(a, 8'hFF, "R1 program without latch leaves data");
    endtask

    task automatic t_program();
        logic [7:0] a, b;
        cmd1(8'h06); prog(24'h0001FE, 3, 8'h12, 8'h34, 8'h56); wait_idle();
        read2(24'h0001FE, a, b);
        chk(a, 8'h12, "R5 program byte 1FE"); chk(b, 8'h34, "R5 program byte 1FF");
        read2(24'h000100, a, b);
        chk(a, 8'h56, "R5 program wraps in page"); chk(b, 8'hFF, "R5 untouched neighbour");
        cmd1(8'h06); prog(24'h0001FE, 1, 8'hF0, 8'h00, 8'h00); wait_idle();
        read2(24'h0001FE, a, b); chk(a, 8'h10, "R5 program ANDs old and new");
    endtask

    task automatic t_read_wrap();
        logic [7:0] a, b;
        cmd1(8'h06); prog(24'h000000, 1, 8'h3C, 8'h00, 8'h00); wait_idle();
        cmd1(8'h06); prog(24'h000FFF, 1, 8'hA5, 8'h00, 8'h00); wait_idle();
        read2(24'h000FFF, a, b);
        chk(a, 8'hA5, "R4 read last byte"); chk(b, 8'h3C, "R4 read wraps to zero");
    endtask

    task automatic t_bitcount();
        logic [7:0] s, a, b, d;
        cmd1(8'h06);
        fbegin(); xfer(8'h20, d); put_addr(24'h000000); send_bits(8'hA0, 3); fend();
        rdsr(s); chk(s, 8'h02, "R7 partial byte erase discarded");
        read2(24'h000000, a, b); chk(a, 8'h3C, "R7 data kept after discarded erase");
        cmd1(8'h04);
    endtask

    task automatic t_sector();
        logic [7:0] a, b;
        cmd1(8'h06); addr_cmd(8'h20, 24'h000123); wait_idle();
        read2(24'h000000, a, b); chk(a, 8'hFF, "R6 sector erase byte 0");
        read2(24'h0001FE, a, b); chk(a, 8'hFF, "R6 sector erase byte 1FE");
        read2(24'h000FFF, a, b); chk(a, 8'hA5, "R6 sector erase spares other sector");
    endtask

    task automatic t_block_busy();
        logic [7:0] s, a, b;
        cmd1(8'h06); addr_cmd(8'hD8, 24'h000900);
        tick(DBE - 600);
        rdsr(s); chk(s, 8'h03, "R8 still busy near end of block erase");
        cmd1(8'h04);
        rdsr(s); chk(s, 8'h03, "R8 write disable ignored while busy");
        wait_idle();
        rdsr(s); chk(s, 8'h00, "R8 busy ends and latch clears");
        read2(24'h000FFF, a, b); chk(a, 8'hFF, "R6 block erase top byte");
    endtask

    task automatic t_protect();
        logic [7:0] s, a, b;
        cmd1(8'h06); wrsr(8'h04); wait_idle();
        rdsr(s); chk(s, 8'h04, "R10 status write protect code");
        cmd1(8'h06); prog(24'h000F00, 1, 8'h00, 8'h00, 8'h00);
        rdsr(s); chk(s, 8'h06, "R9 top eighth refused latch kept");
        read2(24'h000F00, a, b); chk(a, 8'hFF, "R9 protected byte unchanged");
        prog(24'h000D00, 1, 8'h11, 8'h00, 8'h00); wait_idle();
        read2(24'h000D00, a, b); chk(a, 8'h11, "R9 unprotected program accepted");
        cmd1(8'h06); cmd1(8'hC7);
        rdsr(s); chk(s, 8'h06, "R9 chip erase refused with code set");
        wrsr(8'h24); wait_idle();
        rdsr(s); chk(s, 8'h24, "R10 selector written");
        cmd1(8'h06); prog(24'h000100, 1, 8'h00, 8'h00, 8'h00);
        rdsr(s); chk(s, 8'h26, "R9 bottom eighth refused");
        read2(24'h000100, a, b); chk(a, 8'hFF, "R9 bottom byte unchanged");
        cmd1(8'h04);
    endtask

    task automatic t_hw_lock();
        logic [7:0] s;
        cmd1(8'h06); wrsr(8'hA4); wait_idle();
        rdsr(s); chk(s, 8'hA4, "R10 lock bit written");
        wp_n = 1'b0;
        cmd1(8'h06); wrsr(8'h00);
        rdsr(s); chk(s, 8'hA6, "R10 status write ignored under hardware lock");
        wp_n = 1'b1;
        wrsr(8'h00); wait_idle();
        rdsr(s); chk(s, 8'h00, "R10 status write allowed with pin high");
    endtask

    task automatic t_power_down();
        logic [7:0] s, d;
        cmd1(8'h06); cmd1(8'hB9);
        rdsr(s); chk(s, 8'h00, "R11 status read ignored in power-down");
        cmd1(8'h04);
        fbegin(); xfer(8'hAB, d); put_addr(24'h000000); xfer(8'h00, s); fend();
        chk(s, SIG, "R11 release returns signature");
        rdsr(s); chk(s, 8'h02, "R11 write disable ignored while powered down");
    endtask

    initial begin
        tick(10);
        rst_n = 1'b1;
        tick(10);
        t_reset();
        t_latch();
        t_chip_erase();
        t_no_wel();
        t_program();
        t_read_wrap();
        t_bitcount();
        t_sector();
        t_block_busy();
        t_protect();
        t_hw_lock();
        t_power_down();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errs);
            $finish;
        end
    end
endmodule